// File: doc/BRIEF.md
# I2S Clock Prescaler Generator

This block turns a single source clock into the three timing signals of an I2S link: a master clock, a serial bit clock and a word-select (left/right) strobe. A programmable ratio N = 2×DIV + ODD sets the base division. DIV is an 8-bit linear divider and ODD adds one source cycle. Software also selects whether the master clock is driven, the channel length (16-bit data in a 16-bit channel, or a 32-bit channel) and the idle level of the bit clock. The serial data shift path sits outside this block and uses the bit clock and word select produced here.

A two-state controller governs the block. In `ST_IDLE` the configuration inputs are copied into a shadow register on every edge, the outputs rest at their idle levels and all counters are held at zero. The `launch` transition (enable sampled high in `ST_IDLE`) moves to `ST_RUN` and starts every waveform from phase zero. In `ST_RUN` the shadow register is frozen, so configuration changes have no effect. The `halt` transition (enable sampled low in `ST_RUN`) returns to `ST_IDLE`. The self-loops are `hold` in `ST_IDLE` and `stay` in `ST_RUN`. With the master clock on, it runs at 256 times the frame rate and the bit clock is taken from it. With the master clock off, the bit clock runs directly at the prescaled rate. The frame rate is then 32×N or 64×N source cycles, depending on the channel length.

Top module: `i2s_clkgen`

## Requirements
- R1: While reset is asserted, mck_o, ck_o and ws_o are all 0, and the shadow configuration takes DIV=2, ODD=0, master clock off, 16-bit channel and idle-low bit clock.
- R2: If enable is already high when reset is released, the block runs from the reset shadow configuration: the bit clock has a period of 4 source cycles and the master clock stays low.
- R3: With the master clock on, mck_o has a period of N = 2×DIV+ODD source cycles. It is high for the first floor(N/2) cycles of each period.
- R4: A DIV input of 0 is captured as DIV=2 with ODD=0, whatever the ODD input is.
- R5: With the master clock off, mck_o stays 0 and the bit clock has a period of N cycles. It sits at its idle level for the first floor(N/2) cycles and at the opposite level for the rest. A frame lasts 32×N cycles (16-bit channel) or 64×N cycles (32-bit channel).
- R6: With the master clock on, the bit clock period is 8×N (16-bit channel) or 4×N (32-bit channel) cycles. It is at its idle level for the first half. A frame always lasts 256×N cycles.
- R7: ws_o is 0 at launch. It inverts at the start of a bit-clock period once every 16 (16-bit channel) or 32 (32-bit channel) bit-clock periods.
- R8: The polarity input selects the idle level of ck_o. When polarity is 1 the running waveform is inverted, and in `ST_IDLE` ck_o equals the captured polarity.
- R9: Configuration inputs are ignored while the block runs and are captured on every edge where enable is low.
- R10: On the edge after enable is sampled low, all outputs return to idle. On the edge after enable is sampled high again, every waveform restarts from phase zero: mck_o high (if on), ck_o at idle level, ws_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock that all outputs are derived from |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_en | input | 1 | Run enable; configuration loads only while it is low |
| presc_div | input | 8 | Linear divider DIV (0 is treated as 2) |
| presc_odd | input | 1 | Adds one source cycle to the ratio |
| mck_oe | input | 1 | 1 drives the master clock and derives the bit clock from it |
| chan_long | input | 1 | 0: 16-bit channel, 1: 32-bit channel |
| ck_idle_hi | input | 1 | Idle level of the bit clock |
| mck_o | output | 1 | Master clock |
| ck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select |

## Verification
The embedded assertions check, on every cycle, several local properties. The prescale counter stays below the ratio and wraps to zero after its terminal count. Word select changes only on a prescale tick. A launch clears the word-select and bit counters. The shadow configuration does not move while the block runs. The scenarios exercise everything that depends on long-range phase relations: the exact periods and duty of the master and bit clocks for odd and even ratios, frame lengths for every combination of master-clock mode and channel length, divider substitution for zero, the polarity inversion, and restart alignment after a halt. These are compared cycle by cycle against an arithmetic reference model.

// File: rtl/i2sck_pkg.sv
package i2sck_pkg;

    parameter int unsigned PSC_DIV_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RUN
    } i2sck_state_e;

    // Counter command shared by the sub-blocks
    typedef enum logic [1:0] {
        CT_CLR,
        CT_START,
        CT_STEP
    } i2sck_ctl_e;

    typedef struct packed {
        logic [PSC_DIV_W-1:0] div;
        logic                 odd;
        logic                 mck_oe;
        logic                 chan_long;
        logic                 ck_pol;
    } i2sck_cfg_t;

    localparam i2sck_cfg_t CFG_RESET = '{
        div:       PSC_DIV_W'(2),
        odd:       1'b0,
        mck_oe:    1'b0,
        chan_long: 1'b0,
        ck_pol:    1'b0
    };

endpackage

// File: rtl/i2sck_prescale.sv
module i2sck_prescale
    import i2sck_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  i2sck_ctl_e       ctl,
    input  logic [DIV_W:0]   ratio,
    output logic             tick,
    output logic             first_half
);
    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] half;

    assign half = ratio >> 1;
    assign tick = (cnt_q == ratio - 1'b1);

    always_comb begin
        cnt_d = '0;
        if (ctl == CT_STEP) begin
            cnt_d = tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            first_half <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            first_half <= (ctl != CT_CLR) && (cnt_d < half);
        end
    end

    // R3: counter never reaches the ratio while stepping
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CT_STEP) |-> (cnt_q < ratio));

    // R3: terminal count wraps to zero
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CT_STEP && tick) |=> (cnt_q == '0));

endmodule

// File: rtl/i2sck_framer.sv
module i2sck_framer
    import i2sck_pkg::*;
#(
    parameter int unsigned SHORT_BITS = 16,
    parameter int unsigned LONG_BITS  = 32,
    parameter int unsigned MCK_RATIO  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  i2sck_ctl_e ctl,
    input  logic       tick,
    input  logic       mck_oe,
    input  logic       chan_long,
    output logic       ws_q,
    output logic       sub_upper
);
    localparam int unsigned R_SHORT = MCK_RATIO / (2 * SHORT_BITS);
    localparam int unsigned R_LONG  = MCK_RATIO / (2 * LONG_BITS);
    localparam int unsigned SUB_W   = $clog2(R_SHORT);
    localparam int unsigned BIT_W   = $clog2(LONG_BITS);

    logic [SUB_W-1:0] sub_q, sub_d, sub_last;
    logic [BIT_W-1:0] bit_q, bit_d, bit_last;
    logic             ws_d;
    logic             ck_end;

    assign sub_last = chan_long ? SUB_W'(R_LONG - 1) : SUB_W'(R_SHORT - 1);
    assign bit_last = chan_long ? BIT_W'(LONG_BITS - 1) : BIT_W'(SHORT_BITS - 1);

    always_comb begin
        sub_d  = sub_q;
        bit_d  = bit_q;
        ws_d   = ws_q;
        ck_end = 1'b0;
        if (ctl == CT_STEP) begin
            if (tick) begin
                if (mck_oe) begin
                    ck_end = (sub_q == sub_last);
                    sub_d  = ck_end ? '0 : sub_q + 1'b1;
                end else begin
                    ck_end = 1'b1;
                    sub_d  = '0;
                end
                if (ck_end) begin
                    if (bit_q == bit_last) begin
                        bit_d = '0;
                        ws_d  = ~ws_q;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
        end else begin
            sub_d = '0;
            bit_d = '0;
            ws_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q     <= '0;
            bit_q     <= '0;
            ws_q      <= 1'b0;
            sub_upper <= 1'b0;
        end else begin
            sub_q     <= sub_d;
            bit_q     <= bit_d;
            ws_q      <= ws_d;
            sub_upper <= (ctl != CT_CLR) && mck_oe && (sub_d > (sub_last >> 1));
        end
    end

    // R7: word select only moves on a prescale tick
    p_ws_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CT_STEP && !tick) |=> $stable(ws_q));

    // R10: launch clears the frame position
    p_start_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CT_START) |=> (ws_q == 1'b0 && bit_q == '0 && sub_q == '0));

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
    import i2sck_pkg::*;
(
    input  logic       clk_src,
    input  logic       rst_n,
    input  logic       i2s_en,
    input  logic [7:0] presc_div,
    input  logic       presc_odd,
    input  logic       mck_oe,
    input  logic       chan_long,
    input  logic       ck_idle_hi,
    output logic       mck_o,
    output logic       ck_o,
    output logic       ws_o
);
    localparam int unsigned DIV_W = PSC_DIV_W;

    i2sck_state_e       state_q, state_d;
    i2sck_ctl_e         ctl;
    i2sck_cfg_t         cfg_q, cfg_in;
    logic [DIV_W:0]     ratio;
    logic               tick, first_half, ws_int, sub_upper;
    logic               running, ck_base;

    always_comb begin
        cfg_in.div       = (presc_div == '0) ? DIV_W'(2) : presc_div;
        cfg_in.odd       = (presc_div == '0) ? 1'b0 : presc_odd;
        cfg_in.mck_oe    = mck_oe;
        cfg_in.chan_long = chan_long;
        cfg_in.ck_pol    = ck_idle_hi;
    end

    assign ratio = {cfg_q.div, 1'b0} + (DIV_W + 1)'(cfg_q.odd);

    // State register and shadow configuration
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= CFG_RESET;
        end else begin
            state_q <= state_d;
            if (!i2s_en) begin
                cfg_q <= cfg_in;
            end
        end
    end

    // Transitions: hold, launch, stay, halt
    always_comb begin
        state_d = state_q;
        ctl     = CT_CLR;
        unique case (state_q)
            ST_IDLE: begin
                state_d = i2s_en ? ST_RUN : ST_IDLE;
                ctl     = i2s_en ? CT_START : CT_CLR;
            end
            ST_RUN: begin
                state_d = i2s_en ? ST_RUN : ST_IDLE;
                ctl     = i2s_en ? CT_STEP : CT_CLR;
            end
            default: begin
                state_d = ST_IDLE;
                ctl     = CT_CLR;
            end
        endcase
    end

    i2sck_prescale #(.DIV_W(DIV_W)) u_presc (
        .clk        (clk_src),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .ratio      (ratio),
        .tick       (tick),
        .first_half (first_half)
    );

    i2sck_framer #(.SHORT_BITS(16), .LONG_BITS(32), .MCK_RATIO(256)) u_frame (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .tick      (tick),
        .mck_oe    (cfg_q.mck_oe),
        .chan_long (cfg_q.chan_long),
        .ws_q      (ws_int),
        .sub_upper (sub_upper)
    );

    // Output decode
    always_comb begin
        running = (state_q == ST_RUN);
        mck_o   = running && cfg_q.mck_oe && first_half;
        ck_base = running && (cfg_q.mck_oe ? sub_upper : !first_half);
        ck_o    = ck_base ^ cfg_q.ck_pol;
        ws_o    = ws_int;
    end

    // R9: shadow configuration frozen while running
    p_cfg_frozen_r9: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state_q == ST_RUN && i2s_en) |=> $stable(cfg_q));

    // R10: launch lands in the run state with word select low
    p_launch_r10: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state_q == ST_IDLE && i2s_en) |=> (state_q == ST_RUN && ws_o == 1'b0));

endmodule

// File: tb/i2s_clkgen_tb_top.sv
module i2s_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [7:0] div;
    logic       odd, oe, c32, pol;
    logic       mck, ck, ws;

    always #5 clk = ~clk;

    i2s_clkgen dut_i (
        .clk_src(clk), .rst_n(rst_n), .i2s_en(en), .presc_div(div),
        .presc_odd(odd), .mck_oe(oe), .chan_long(c32), .ck_idle_hi(pol),
        .mck_o(mck), .ck_o(ck), .ws_o(ws)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 1'b0;
    string scen  = "R1";

    // reference model state
    bit     m_run;
    int     m_t;
    int     m_div, m_odd, m_oe, m_c32, m_pol;

    // word-select interval monitor
    int     last_edge = -1;
    int     meas = -1;
    logic   ws_prev = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] cycle %0d actual=%0d expected=%0d", tag, scen, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_t = 0;
            m_div = 2; m_odd = 0; m_oe = 0; m_c32 = 0; m_pol = 0;
        end else if (!en) begin
            m_run = 0;
            m_div = (div == 0) ? 2 : int'(div);
            m_odd = (div == 0) ? 0 : int'(odd);
            m_oe  = int'(oe); m_c32 = int'(c32); m_pol = int'(pol);
        end else if (!m_run) begin
            m_run = 1; m_t = 0;
        end else begin
            m_t++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n, p, l, e_mck, e_ckb, e_ws;
            n = 2 * m_div + m_odd;
            p = m_oe ? n * (m_c32 ? 4 : 8) : n;
            l = m_c32 ? 32 : 16;
            if (m_run) begin
                e_mck = (m_oe != 0 && (m_t % n) < n / 2) ? 1 : 0;
                e_ckb = ((m_t % p) >= p / 2) ? 1 : 0;
                e_ws  = (m_t / (p * l)) % 2;
            end else begin
                e_mck = 0; e_ckb = 0; e_ws = 0;
            end
            chk("R3 mck", int'(mck), e_mck);
            chk(m_run ? (m_oe != 0 ? "R6 ck" : "R5 ck") : "R8 ck idle", int'(ck), e_ckb ^ m_pol);
            chk("R7 ws", int'(ws), e_ws);
            if (ws !== ws_prev) begin
                if (last_edge >= 0) meas = cyc - last_edge;
                last_edge = cyc;
            end
            ws_prev = ws;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic new_scen(string s);
        scen = s; last_edge = -1; meas = -1;
    endtask

    task automatic setcfg(int d, int o, int e, int c, int pl);
        div = 8'(d); odd = 1'(o); oe = 1'(e); c32 = 1'(c); pol = 1'(pl);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b1;
        setcfg(9, 1, 1, 1, 1);
        run(3);
        chk("R1 mck reset", int'(mck), 0);
        chk("R1 ck reset", int'(ck), 0);
        chk("R1 ws reset", int'(ws), 0);
        // R2: enable held through reset, reset shadow gives N=4, master clock off
        new_scen("R2");
        rst_n = 1'b1;
        run(300);
        chk("R2 half frame 16x4", meas, 64);
        // R3/R6: N=3, master clock on, 16-bit channel
        en = 1'b0; setcfg(1, 1, 1, 0, 0); run(3);
        new_scen("R3"); en = 1'b1; run(1600);
        chk("R6 half frame 128x3", meas, 384);
        // R5: N=5, master clock off, 32-bit channel
        en = 1'b0; setcfg(2, 1, 0, 1, 0); run(2);
        new_scen("R5"); en = 1'b1; run(700);
        chk("R5 half frame 32x5", meas, 160);
        // R4/R8: zero divider with odd set, master clock on, 32-bit, inverted clock
        en = 1'b0; setcfg(0, 1, 1, 1, 1); run(2);
        new_scen("R4"); en = 1'b1; run(1100);
        chk("R4 half frame 128x4", meas, 512);
        // R9: configuration changes while running are ignored
        new_scen("R9"); setcfg(7, 0, 0, 0, 0); run(1100);
        chk("R9 half frame unchanged", meas, 512);
        // R10: halt, idle with polarity changing, restart
        new_scen("R10"); en = 1'b0; run(4);
        pol = 1'b1; run(3);
        chk("R8 idle level high", int'(ck), 1);
        pol = 1'b0; run(3);
        chk("R8 idle level low", int'(ck), 0);
        setcfg(3, 0, 1, 0, 0); run(1);
        en = 1'b1; run(1);
        chk("R10 restart mck high", int'(mck), 1);
        chk("R10 restart ws low", int'(ws), 0);
        run(1000);
        // R5: largest ratio, master clock off, 16-bit channel
        en = 1'b0; setcfg(255, 1, 0, 0, 1); run(2);
        new_scen("R5 max"); en = 1'b1; run(17000);
        chk("R5 half frame 16x511", meas, 8176);
        en = 1'b0; run(2);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", scen, cyc, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule